// File: doc/BRIEF.md
# Clock Ratio Control Register Block

This block is a register-mapped clock controller. Software programs a clock configuration word, a PLL control word and a set of peripheral divider registers through a simple 32-bit read/write port. From these registers the block derives the multiply and divide ratio of the PLL, and one divide ratio for each of eight clock domains: core, high-speed bus, peripheral bus, memory, LCD, USB, I2S and MMC.

The PLL is not modelled as an analog loop. It is reduced to a ratio pair on two output buses. Each domain drives a single-cycle strobe that fires once every N cycles of `clk_i`, where N is that domain's effective divide ratio. Downstream logic uses these strobes as clock enables. When a ratio changes, the counter for that domain restarts from the new ratio, so a partial count from the old setting never carries over.

Top module: `clk_ctrl_unit`

## Requirements
- R1: After reset, each register reads back as follows: configuration (offset 0x00) 0x42040000, PLL control (0x10) 0x28080011, USB test (0x70) 0. The I2S divider (0x60), LCD pixel divider (0x64), MMC divider (0x68), USB host divider (0x6C) and SSI divider (0x74) each read 4.
- R2: The configuration and PLL control words keep all 32 bits. The other registers keep only their low bits: I2S 9, LCD pixel 11, MMC 5, USB host 4, USB test 6 and SSI 4. Their upper bits read as zero. Read data is combinational while `reg_re_i` is high, and zero when it is low.
- R3: Any access to an offset outside the eight listed is handled as follows. A read returns 0 and a write changes no register. In both cases `reg_err_o` is high during the cycle after the access, and low after any cycle that has no access.
- R4: The PLL is active when PLL control bit 8 (enable) is 1 and bit 9 (bypass) is 0. In that case `pll_mul_o` = M+2, where M is bits [31:23]. `pll_div_o` = (N+2)×OD, where N is bits [22:18] and OD is selected by bits [17:16] from {1,2,2,4}.
- R5: The PLL is bypassed when the enable bit is 0, or when the bypass bit is 1. In bypass both ratio outputs are 1. A PLL control write that selects bypass is stored with bit 10 (stable) forced to 1. This also holds after reset, because the reset word has the enable bit clear.
- R6: The core, high-speed bus, peripheral bus and memory strobes have periods taken from the table {1,2,3,4,6,8,12,16,24,32}. The table is indexed by configuration bits [3:0], [7:4], [11:8] and [15:12] respectively. Any index above 9 gives 32.
- R7: The LCD strobe period is configuration bits [20:16] plus one.
- R8: The USB strobe period is the table entry for configuration bits [28:23], with indices above 9 giving 32. When bit 29 is 1, that entry is multiplied by the post-PLL divide. The post-PLL divide is 1 if configuration bit 21 is 1, and 2 if it is 0. When bit 29 is 0, no multiplier applies.
- R9: The I2S strobe period is the I2S divider plus one. It is multiplied by the post-PLL divide when configuration bit 31 is 1. The MMC strobe period is the MMC divider plus one.
- R10: When a write changes a domain's ratio to R, that domain's strobe stays low until exactly R+1 rising edges after the edge that captured the write. From then on it has period R, whatever count the old ratio had reached.
- R11: Rewriting a divider register with the value it already holds leaves the phase of that domain's strobe unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid while reg_re_i is high |
| reg_err_o | output | 1 | Pulse for an access to an undefined offset |
| pll_mul_o | output | 10 | Effective PLL multiply ratio |
| pll_div_o | output | 8 | Effective PLL divide ratio |
| dom_stb_o | output | 8 | Domain strobes: core, high-speed bus, peripheral bus, memory, LCD, USB, I2S, MMC (bit 0 first) |

## Verification
The bench builds the block with its default widths: an 8-bit offset, 11-bit domain ratios and the 9-bit I2S field. With these widths the largest period, an I2S divide of 512 doubled by the post-PLL divide, fits without truncation. The random configurations keep the I2S divider below 64, so every domain's period can be measured across all eight domains within a short run. Directed cases cover the following:
- table saturation on the 4-bit and 6-bit indices;
- both bypass conditions;
- a reload from a long ratio partway through its count;
- a same-value rewrite timed against a strobe.

// File: rtl/clk_ctrl_pkg.sv
package clk_ctrl_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int NDOM    = 8;
  localparam int RATIO_W = 11;
  localparam int MUL_W   = 10;
  localparam int DIV_W   = 8;

  localparam int DOM_CORE = 0;
  localparam int DOM_HBUS = 1;
  localparam int DOM_PBUS = 2;
  localparam int DOM_MEM  = 3;
  localparam int DOM_LCD  = 4;
  localparam int DOM_USB  = 5;
  localparam int DOM_I2S  = 6;
  localparam int DOM_MMC  = 7;

  localparam logic [ADDR_W-1:0] OFS_CFG = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PLL = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_I2S = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_LCD = 8'h64;
  localparam logic [ADDR_W-1:0] OFS_MMC = 8'h68;
  localparam logic [ADDR_W-1:0] OFS_UHC = 8'h6C;
  localparam logic [ADDR_W-1:0] OFS_TST = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_SSI = 8'h74;

  localparam int I2S_W = 9;
  localparam int LCD_W = 11;
  localparam int MMC_W = 5;
  localparam int UHC_W = 4;
  localparam int TST_W = 6;
  localparam int SSI_W = 4;

  // configuration word fields
  localparam int CF_CDIV  = 0;
  localparam int CF_HDIV  = 4;
  localparam int CF_PDIV  = 8;
  localparam int CF_MDIV  = 12;
  localparam int CF_IDX_W = 4;
  localparam int CF_LDIV  = 16;
  localparam int CF_LDV_W = 5;
  localparam int CF_PDSEL = 21;
  localparam int CF_UDIV  = 23;
  localparam int CF_UDV_W = 6;
  localparam int CF_USRC  = 29;
  localparam int CF_ISRC  = 31;

  // PLL control fields
  localparam int PL_EN  = 8;
  localparam int PL_BYP = 9;
  localparam int PL_STB = 10;
  localparam int PL_OD  = 16;
  localparam int PL_N   = 18;
  localparam int PL_N_W = 5;
  localparam int PL_M   = 23;
  localparam int PL_M_W = 9;

  localparam logic [DATA_W-1:0] CFG_RST = 32'h4204_0000;
  localparam logic [DATA_W-1:0] PLL_RST = 32'h2808_0011;
  localparam int                DIV_RST = 4;

  function automatic logic [5:0] div_lut(input logic [5:0] idx);
    case (idx)
      6'd0:    return 6'd1;
      6'd1:    return 6'd2;
      6'd2:    return 6'd3;
      6'd3:    return 6'd4;
      6'd4:    return 6'd6;
      6'd5:    return 6'd8;
      6'd6:    return 6'd12;
      6'd7:    return 6'd16;
      6'd8:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [2:0] od_lut(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd1;
      2'd3:    return 3'd4;
      default: return 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/clk_ctrl_regs.sv
module clk_ctrl_regs import clk_ctrl_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] pll_o,
  output logic [I2S_W-1:0]  i2s_o,
  output logic [MMC_W-1:0]  mmc_o
);
  logic [DATA_W-1:0] cfg_q, pll_q;
  logic [I2S_W-1:0]  i2s_q;
  logic [LCD_W-1:0]  lcd_q;
  logic [MMC_W-1:0]  mmc_q;
  logic [UHC_W-1:0]  uhc_q;
  logic [TST_W-1:0]  tst_q;
  logic [SSI_W-1:0]  ssi_q;
  logic              err_q;
  logic              hit;
  logic              pll_bypass_w;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    hit = 1'b1;
    rd_mux = '0;
    case (addr_i)
      OFS_CFG: rd_mux = cfg_q;
      OFS_PLL: rd_mux = pll_q;
      OFS_I2S: rd_mux = DATA_W'(i2s_q);
      OFS_LCD: rd_mux = DATA_W'(lcd_q);
      OFS_MMC: rd_mux = DATA_W'(mmc_q);
      OFS_UHC: rd_mux = DATA_W'(uhc_q);
      OFS_TST: rd_mux = DATA_W'(tst_q);
      OFS_SSI: rd_mux = DATA_W'(ssi_q);
      default: hit = 1'b0;
    endcase
  end

  assign pll_bypass_w = !wdata_i[PL_EN] || wdata_i[PL_BYP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      pll_q <= PLL_RST;
      i2s_q <= I2S_W'(DIV_RST);
      lcd_q <= LCD_W'(DIV_RST);
      mmc_q <= MMC_W'(DIV_RST);
      uhc_q <= UHC_W'(DIV_RST);
      tst_q <= '0;
      ssi_q <= SSI_W'(DIV_RST);
    end else if (we_i) begin
      case (addr_i)
        OFS_CFG: cfg_q <= wdata_i;
        OFS_PLL: begin
          pll_q <= wdata_i;
          if (pll_bypass_w) pll_q[PL_STB] <= 1'b1;
        end
        OFS_I2S: i2s_q <= wdata_i[I2S_W-1:0];
        OFS_LCD: lcd_q <= wdata_i[LCD_W-1:0];
        OFS_MMC: mmc_q <= wdata_i[MMC_W-1:0];
        OFS_UHC: uhc_q <= wdata_i[UHC_W-1:0];
        OFS_TST: tst_q <= wdata_i[TST_W-1:0];
        OFS_SSI: ssi_q <= wdata_i[SSI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= (we_i || re_i) && !hit;
  end

  assign rdata_o = re_i ? rd_mux : '0;
  assign err_o   = err_q;
  assign cfg_o   = cfg_q;
  assign pll_o   = pll_q;
  assign i2s_o   = i2s_q;
  assign mmc_o   = mmc_q;
endmodule

// File: rtl/clk_ctrl_ratio.sv
module clk_ctrl_ratio import clk_ctrl_pkg::*; (
  input  logic [DATA_W-1:0]             cfg_i,
  input  logic [DATA_W-1:0]             pll_i,
  input  logic [I2S_W-1:0]              i2s_i,
  input  logic [MMC_W-1:0]              mmc_i,
  output logic [NDOM-1:0][RATIO_W-1:0]  ratio_o,
  output logic [MUL_W-1:0]              mul_o,
  output logic [DIV_W-1:0]              div_o
);
  logic               pll_on;
  logic [RATIO_W-1:0] pre_div, usb_mul, i2s_mul;
  logic               unused_cfg, unused_pll;

  assign unused_cfg = ^{cfg_i[30], cfg_i[22]};
  assign unused_pll = ^{pll_i[15:10], pll_i[7:0]};

  assign pll_on = pll_i[PL_EN] && !pll_i[PL_BYP];
  assign mul_o  = pll_on ? MUL_W'(pll_i[PL_M +: PL_M_W]) + MUL_W'(2) : MUL_W'(1);
  assign div_o  = pll_on ? (DIV_W'(pll_i[PL_N +: PL_N_W]) + DIV_W'(2)) * DIV_W'(od_lut(pll_i[PL_OD +: 2]))
                         : DIV_W'(1);

  assign pre_div = cfg_i[CF_PDSEL] ? RATIO_W'(1) : RATIO_W'(2);
  assign usb_mul = cfg_i[CF_USRC]  ? pre_div     : RATIO_W'(1);
  assign i2s_mul = cfg_i[CF_ISRC]  ? pre_div     : RATIO_W'(1);

  always_comb begin
    ratio_o[DOM_CORE] = RATIO_W'(div_lut(6'(cfg_i[CF_CDIV +: CF_IDX_W])));
    ratio_o[DOM_HBUS] = RATIO_W'(div_lut(6'(cfg_i[CF_HDIV +: CF_IDX_W])));
    ratio_o[DOM_PBUS] = RATIO_W'(div_lut(6'(cfg_i[CF_PDIV +: CF_IDX_W])));
    ratio_o[DOM_MEM]  = RATIO_W'(div_lut(6'(cfg_i[CF_MDIV +: CF_IDX_W])));
    ratio_o[DOM_LCD]  = RATIO_W'(cfg_i[CF_LDIV +: CF_LDV_W]) + RATIO_W'(1);
    ratio_o[DOM_USB]  = RATIO_W'(div_lut(cfg_i[CF_UDIV +: CF_UDV_W])) * usb_mul;
    ratio_o[DOM_I2S]  = (RATIO_W'(i2s_i) + RATIO_W'(1)) * i2s_mul;
    ratio_o[DOM_MMC]  = RATIO_W'(mmc_i) + RATIO_W'(1);
  end
endmodule

// File: rtl/clk_ctrl_stb.sv
module clk_ctrl_stb #(
  parameter int RW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ratio_i,
  output logic          stb_o
);
  logic [RW-1:0] ratio_q, cnt_q;
  logic          stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= '0;
      cnt_q   <= '0;
      stb_q   <= 1'b0;
    end else begin
      ratio_q <= ratio_i;
      if (ratio_i != ratio_q) begin
        // restart on any ratio change, drop the partial count
        cnt_q <= ratio_i - RW'(1);
        stb_q <= 1'b0;
      end else if (cnt_q == '0) begin
        cnt_q <= ratio_i - RW'(1);
        stb_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - RW'(1);
        stb_q <= 1'b0;
      end
    end
  end

  assign stb_o = stb_q;
endmodule

// File: rtl/clk_ctrl_unit.sv
module clk_ctrl_unit import clk_ctrl_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_err_o,
  output logic [MUL_W-1:0]  pll_mul_o,
  output logic [DIV_W-1:0]  pll_div_o,
  output logic [NDOM-1:0]   dom_stb_o
);
  logic [DATA_W-1:0]            cfg_w, pll_w;
  logic [I2S_W-1:0]             i2s_w;
  logic [MMC_W-1:0]             mmc_w;
  logic [NDOM-1:0][RATIO_W-1:0] dom_ratio;

  clk_ctrl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .re_i    (reg_re_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .err_o   (reg_err_o),
    .cfg_o   (cfg_w),
    .pll_o   (pll_w),
    .i2s_o   (i2s_w),
    .mmc_o   (mmc_w)
  );

  clk_ctrl_ratio u_ratio (
    .cfg_i   (cfg_w),
    .pll_i   (pll_w),
    .i2s_i   (i2s_w),
    .mmc_i   (mmc_w),
    .ratio_o (dom_ratio),
    .mul_o   (pll_mul_o),
    .div_o   (pll_div_o)
  );

  for (genvar d = 0; d < NDOM; d++) begin : g_stb
    clk_ctrl_stb #(.RW(RATIO_W)) u_stb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ratio_i (dom_ratio[d]),
      .stb_o   (dom_stb_o[d])
    );
  end
endmodule

// File: rtl/clk_ctrl_unit_chk.sv
module clk_ctrl_unit_chk import clk_ctrl_pkg::*; (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         reg_we_i,
  input logic                         reg_re_i,
  input logic [ADDR_W-1:0]            reg_addr_i,
  input logic [DATA_W-1:0]            reg_wdata_i,
  input logic [DATA_W-1:0]            reg_rdata_o,
  input logic                         reg_err_o,
  input logic [MUL_W-1:0]             pll_mul_o,
  input logic [DIV_W-1:0]             pll_div_o,
  input logic [NDOM-1:0]              dom_stb_o,
  input logic [NDOM-1:0][RATIO_W-1:0] dom_ratio_i
);
  logic known, acc, pll_wr;
  assign known  = reg_addr_i inside {OFS_CFG, OFS_PLL, OFS_I2S, OFS_LCD,
                                     OFS_MMC, OFS_UHC, OFS_TST, OFS_SSI};
  assign acc    = reg_we_i || reg_re_i;
  assign pll_wr = reg_we_i && (reg_addr_i == OFS_PLL);

  // R3
  bad_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && !known) |-> (reg_rdata_o == '0));
  // R3
  bad_access_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !known) |=> reg_err_o);
  // R3
  idle_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !reg_err_o);
  // R5
  bypass_unity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_wr && (!reg_wdata_i[PL_EN] || reg_wdata_i[PL_BYP])) |=>
      (pll_mul_o == MUL_W'(1) && pll_div_o == DIV_W'(1)));
  // R4
  pll_mul_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_wr && reg_wdata_i[PL_EN] && !reg_wdata_i[PL_BYP]) |=>
      (pll_mul_o == MUL_W'($past(reg_wdata_i[PL_M +: PL_M_W])) + MUL_W'(2)));

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    // R10
    reload_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dom_ratio_i[d] != $past(dom_ratio_i[d])) |=> !dom_stb_o[d]);
  end
endmodule

bind clk_ctrl_unit clk_ctrl_unit_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_re_i    (reg_re_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .reg_err_o   (reg_err_o),
  .pll_mul_o   (pll_mul_o),
  .pll_div_o   (pll_div_o),
  .dom_stb_o   (dom_stb_o),
  .dom_ratio_i (dom_ratio)
);

// File: tb/clk_ctrl_unit_tb_top.sv
module clk_ctrl_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [9:0]  mul;
  logic [7:0]  div;
  logic [7:0]  stb;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  clk_ctrl_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .reg_err_o(err), .pll_mul_o(mul), .pll_div_o(div), .dom_stb_o(stb));

  function automatic int lut(int i);
    case (i)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;  4: return 6;
      5: return 8;  6: return 12; 7: return 16; 8: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic int exp_ratio(logic [31:0] c, int i2s, int mmc, int d);
    int pre;
    pre = c[21] ? 1 : 2;
    case (d)
      0: return lut(int'(c[3:0]));
      1: return lut(int'(c[7:4]));
      2: return lut(int'(c[11:8]));
      3: return lut(int'(c[15:12]));
      4: return int'(c[20:16]) + 1;
      5: return lut(int'(c[28:23])) * (c[29] ? pre : 1);
      6: return (i2s + 1) * (c[31] ? pre : 1);
      default: return mmc + 1;
    endcase
  endfunction

  function automatic int exp_mul(logic [31:0] p);
    return (p[8] && !p[9]) ? int'(p[31:23]) + 2 : 1;
  endfunction

  function automatic int exp_div(logic [31:0] p);
    int od;
    case (p[17:16]) 2'd0: od = 1; 2'd3: od = 4; default: od = 2; endcase
    return (p[8] && !p[9]) ? (int'(p[22:18]) + 2) * od : 1;
  endfunction

  function automatic string dom_req(int d);
    if (d < 4) return "R6";
    if (d == 4) return "R7";
    if (d == 5) return "R8";
    return "R9";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic period(int d, output int p);
    int n;
    n = 0;
    while (!stb[d] && n < 5000) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!stb[d] && n < 5000);
    p = n;
  endtask

  task automatic check_domains(logic [31:0] c, int i2s, int mmc);
    int p;
    for (int d = 0; d < 8; d++) begin
      period(d, p);
      chk(dom_req(d), p, exp_ratio(c, i2s, mmc, d));
    end
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, cw, pw;
    int n, iv, mv;
    void'($urandom(32'h5eed_c1c0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(8'h00, v); chk("R1", v, 32'h4204_0000);
    rd(8'h10, v); chk("R1", v, 32'h2808_0011);
    rd(8'h60, v); chk("R1", v, 4);
    rd(8'h64, v); chk("R1", v, 4);
    rd(8'h68, v); chk("R1", v, 4);
    rd(8'h6C, v); chk("R1", v, 4);
    rd(8'h70, v); chk("R1", v, 0);
    rd(8'h74, v); chk("R1", v, 4);
    // R5 reset word has enable clear
    chk("R5", mul, 1); chk("R5", div, 1);
    // R6 R7 R8 R9 at reset values
    @(negedge clk); @(negedge clk);
    check_domains(32'h4204_0000, 4, 4);

    // R2 masking
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R2", v, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF); rd(8'h60, v); chk("R2", v, 32'h1FF);
    wr(8'h64, 32'hFFFF_FFFF); rd(8'h64, v); chk("R2", v, 32'h7FF);
    wr(8'h68, 32'hFFFF_FFFF); rd(8'h68, v); chk("R2", v, 32'h1F);
    wr(8'h6C, 32'hFFFF_FFFF); rd(8'h6C, v); chk("R2", v, 32'hF);
    wr(8'h70, 32'hFFFF_FFFF); rd(8'h70, v); chk("R2", v, 32'h3F);
    wr(8'h74, 32'hFFFF_FFFF); rd(8'h74, v); chk("R2", v, 32'hF);
    @(negedge clk); chk("R2", rdata, 0);

    // R3 undefined offsets
    wr(8'h00, 32'h0000_0000);
    rd(8'h04, v); chk("R3", v, 0); chk("R3", err, 1);
    @(negedge clk); chk("R3", err, 0);
    wr(8'h08, 32'h1234_5678); chk("R3", err, 1);
    rd(8'h00, v); chk("R3", v, 0); chk("R3", err, 0);
    wr(8'h61, 32'h0000_0077); rd(8'h60, v); chk("R3", v, 32'h1FF);

    // R4 active PLL
    pw = 32'h1234_5100;
    wr(8'h10, pw); rd(8'h10, v); chk("R4", v, pw);
    chk("R4", mul, exp_mul(pw)); chk("R4", div, exp_div(pw));
    for (int k = 0; k < 6; k++) begin
      pw = $urandom; pw[8] = 1'b1; pw[9] = 1'b0;
      wr(8'h10, pw); @(negedge clk);
      chk("R4", mul, exp_mul(pw)); chk("R4", div, exp_div(pw));
    end
    // R5 both bypass conditions
    wr(8'h10, 32'h0000_0000); rd(8'h10, v); chk("R5", v, 32'h0000_0400);
    chk("R5", mul, 1); chk("R5", div, 1);
    wr(8'h10, 32'hABC0_0300); rd(8'h10, v); chk("R5", v, 32'hABC0_0700);
    chk("R5", mul, 1); chk("R5", div, 1);

    // R6 R8 saturation of indices above 9
    cw = 32'h3FA0_FFFF;
    wr(8'h60, 3); wr(8'h68, 7); wr(8'h00, cw);
    @(negedge clk); @(negedge clk);
    check_domains(cw, 3, 7);
    cw = 32'h0F80_ABCD;
    wr(8'h00, cw); @(negedge clk); @(negedge clk);
    check_domains(cw, 3, 7);

    // R6..R9 random configurations
    for (int k = 0; k < 6; k++) begin
      cw = $urandom; iv = int'($urandom % 64); mv = int'($urandom % 32);
      wr(8'h60, iv); wr(8'h68, mv); wr(8'h00, cw);
      @(negedge clk); @(negedge clk);
      check_domains(cw, iv, mv);
    end

    // R10 reload mid-count: core from 32 to 8
    wr(8'h00, 32'h0000_0009);
    repeat (13) @(negedge clk);
    wr(8'h00, 32'h0000_0005);
    n = 0;
    do begin @(negedge clk); n++; end while (!stb[0] && n < 100);
    chk("R10", n, 9);
    period(0, n); chk("R10", n, 8);

    // R11 same-value rewrite keeps phase (I2S ratio 10, MMC ratio 12)
    wr(8'h00, 32'h0000_0000); wr(8'h60, 9); wr(8'h68, 11);
    repeat (30) @(negedge clk);
    n = 0;
    while (!stb[6] && n < 100) begin @(negedge clk); n++; end
    wr(8'h60, 9);
    n = 2;
    do begin @(negedge clk); n++; end while (!stb[6] && n < 100);
    chk("R11", n, 10);
    n = 0;
    while (!stb[7] && n < 100) begin @(negedge clk); n++; end
    wr(8'h68, 11);
    n = 2;
    do begin @(negedge clk); n++; end while (!stb[7] && n < 100);
    chk("R11", n, 12);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule